// File: doc/BRIEF.md
# Branch Target Generator

This block works out where the program counter of a small 8-bit controller with a 16-bit code space goes next. It handles four kinds of control transfer:

- a short conditional hop measured from the instruction's end;
- a jump that stays inside the current 2K code page;
- a full-range jump;
- a jump through the accumulator added to the data pointer.

It also handles the two table-lookup forms that read a code byte. For those it produces the byte's address as well as the next program counter.

The instruction decoder presents one request per cycle. A request carries:

- the form code;
- the current program counter;
- up to three instruction bytes;
- the accumulator and the data pointer;
- the branch-condition result.

The result appears on registered outputs in the following cycle. When no request is presented, the outputs keep their last values and the valid strobe stays low.

Form codes on `form`:

| Code | Form |
|------|------|
| 0 | relative |
| 1 | page-absolute |
| 2 | long |
| 3 | accumulator-indexed jump |
| 4 | code fetch from counter plus accumulator |
| 5 | code fetch from pointer plus accumulator |
| 6, 7 | reserved |

Top module: `brgen_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid`, `fetch_en`, `next_pc` and `fetch_addr` are all zero.
- R2: A request accepted on a clock edge (`req_valid` high) raises `out_valid` for exactly the following cycle, with its result on the other outputs in that cycle.
- R3: Form 0 with `cond_true` high gives `next_pc` = `pc` + 2 + the sign-extended `ibyte1`, so the reach is -128 to +127 from the advanced counter.
- R4: Form 0 with `cond_true` low gives `next_pc` = `pc` + 2, whatever `ibyte1` holds.
- R5: Form 1 gives `next_pc` = {bits 15..11 of `pc`+2, `ibyte0` bits 7..5, `ibyte1`}. The result stays in the 2K page of `pc`+2, even when that page differs from the page of `pc`.
- R6: Form 2 gives `next_pc` = {`ibyte1`, `ibyte2`}, with `ibyte1` as the high byte.
- R7: Form 3 gives `next_pc` = `dptr` + the zero-extended `acc`.
- R8: Form 4 gives `next_pc` = `pc` + 1, `fetch_addr` = `pc` + 1 + the zero-extended `acc`, and `fetch_en` = 1.
- R9: Form 5 gives `next_pc` = `pc` + 1, `fetch_addr` = `dptr` + the zero-extended `acc`, and `fetch_en` = 1.
- R10: Forms 0 to 3 give `fetch_en` = 0 and `fetch_addr` = 0.
- R11: Every 16-bit sum wraps modulo 65536.
- R12: A cycle without a request leaves `next_pc`, `fetch_addr` and `fetch_en` unchanged and drives `out_valid` low.
- R13: Reserved forms 6 and 7 give `next_pc` = `pc` + 1, `fetch_en` = 0 and `fetch_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| form | input | 3 | Transfer form code |
| pc | input | 16 | Address of the current instruction |
| ibyte0 | input | 8 | Opcode byte |
| ibyte1 | input | 8 | Second instruction byte |
| ibyte2 | input | 8 | Third instruction byte |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| cond_true | input | 1 | Relative-branch condition result |
| out_valid | output | 1 | Result valid |
| next_pc | output | 16 | Next program counter |
| fetch_addr | output | 16 | Code-byte address for the fetch forms |
| fetch_en | output | 1 | Fetch address is meaningful |

## Verification
The bench builds the block with its default 8-bit data width and 16-bit address width, which is small enough to enumerate whole operand ranges. It covers:

- every displacement, with the condition both true and false, from counters near zero, mid-range and the top of the space;
- every value of the three opcode page bits, from counters whose advance crosses a page or wraps the space;
- every accumulator value, against pointers and counters that force carries out of bit 15.

Together these reach each wrap and page-crossing corner with exact arithmetic expectations.

// File: rtl/brgen_pkg.sv
package brgen_pkg;

    localparam int unsigned BG_DATA_W = 8;
    localparam int unsigned BG_FORM_W = 3;

    typedef enum logic [BG_FORM_W-1:0] {
        FORM_REL   = 3'd0,
        FORM_PAGE  = 3'd1,
        FORM_LONG  = 3'd2,
        FORM_IJMP  = 3'd3,
        FORM_FPC   = 3'd4,
        FORM_FPTR  = 3'd5,
        FORM_RSV6  = 3'd6,
        FORM_RSV7  = 3'd7
    } form_e;

    function automatic logic form_fetches(input form_e f);
        return (f == FORM_FPC) || (f == FORM_FPTR);
    endfunction

    function automatic logic form_reserved(input form_e f);
        return (f == FORM_RSV6) || (f == FORM_RSV7);
    endfunction

endpackage

// File: rtl/brgen_rel.sv
module brgen_rel #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] disp,
    input  logic              take,
    output logic [ADDR_W-1:0] target
);
    localparam int unsigned EXT_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] advanced;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        advanced = pc + ADDR_W'(2);
        offset   = take ? {{EXT_W{disp[DATA_W-1]}}, disp} : '0;
        target   = advanced + offset;
    end
endmodule

// File: rtl/brgen_page.sv
module brgen_page #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] opcode,
    input  logic [DATA_W-1:0] low,
    output logic [ADDR_W-1:0] target
);
    localparam int unsigned SEL_W = 3;
    localparam int unsigned OFF_W = DATA_W + SEL_W;

    logic [ADDR_W-1:0] advanced;

    always_comb begin
        advanced = pc + ADDR_W'(2);
        target   = {advanced[ADDR_W-1:OFF_W], opcode[DATA_W-1 -: SEL_W], low};
    end
endmodule

// File: rtl/brgen_index.sv
module brgen_index #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] index,
    output logic [ADDR_W-1:0] sum
);
    localparam int unsigned PAD_W = ADDR_W - DATA_W;

    assign sum = base + {{PAD_W{1'b0}}, index};
endmodule

// File: rtl/brgen_top.sv
module brgen_top
    import brgen_pkg::*;
#(
    parameter int unsigned DATA_W = BG_DATA_W,
    localparam int unsigned ADDR_W = 2 * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [BG_FORM_W-1:0] form,
    input  logic [ADDR_W-1:0]    pc,
    input  logic [DATA_W-1:0]    ibyte0,
    input  logic [DATA_W-1:0]    ibyte1,
    input  logic [DATA_W-1:0]    ibyte2,
    input  logic [DATA_W-1:0]    acc,
    input  logic [ADDR_W-1:0]    dptr,
    input  logic                 cond_true,
    output logic                 out_valid,
    output logic [ADDR_W-1:0]    next_pc,
    output logic [ADDR_W-1:0]    fetch_addr,
    output logic                 fetch_en
);
    typedef struct packed {
        logic [ADDR_W-1:0] npc;
        logic [ADDR_W-1:0] faddr;
        logic              fen;
    } result_t;

    form_e             sel;
    logic [ADDR_W-1:0] rel_tgt;
    logic [ADDR_W-1:0] page_tgt;
    logic [ADDR_W-1:0] ptr_sum;
    logic [ADDR_W-1:0] pc_next1;
    logic [ADDR_W-1:0] pc_sum;
    result_t           res_d;
    result_t           res_q;
    logic              vld_q;

    assign sel      = form_e'(form);
    assign pc_next1 = pc + ADDR_W'(1);

    brgen_rel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rel_i (
        .pc(pc), .disp(ibyte1), .take(cond_true), .target(rel_tgt)
    );

    brgen_page #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) page_i (
        .pc(pc), .opcode(ibyte0), .low(ibyte1), .target(page_tgt)
    );

    brgen_index #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ptr_i (
        .base(dptr), .index(acc), .sum(ptr_sum)
    );

    brgen_index #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) pcx_i (
        .base(pc_next1), .index(acc), .sum(pc_sum)
    );

    always_comb begin
        res_d       = '0;
        res_d.fen   = form_fetches(sel);
        res_d.npc   = pc_next1;
        case (sel)
            FORM_REL:  res_d.npc = rel_tgt;
            FORM_PAGE: res_d.npc = page_tgt;
            FORM_LONG: res_d.npc = {ibyte1, ibyte2};
            FORM_IJMP: res_d.npc = ptr_sum;
            FORM_FPC:  res_d.faddr = pc_sum;
            FORM_FPTR: res_d.faddr = ptr_sum;
            default:   res_d.npc = pc_next1;
        endcase
        if (form_reserved(sel)) begin
            res_d.fen   = 1'b0;
            res_d.faddr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= req_valid;
            if (req_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign out_valid  = vld_q;
    assign next_pc    = res_q.npc;
    assign fetch_addr = res_q.faddr;
    assign fetch_en   = res_q.fen;
endmodule

// File: rtl/brgen_chk.sv
module brgen_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        form,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] ibyte0,
    input logic [DATA_W-1:0] ibyte1,
    input logic [DATA_W-1:0] ibyte2,
    input logic              cond_true,
    input logic              out_valid,
    input logic [ADDR_W-1:0] next_pc,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_en
);
    localparam int unsigned OFF_W = DATA_W + 3;

    logic [ADDR_W-1:0] pc_p2;
    assign pc_p2 = pc + ADDR_W'(2);

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid && $stable(next_pc) && $stable(fetch_addr) && $stable(fetch_en));

    // R4
    rel_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && form == 3'd0 && !cond_true |=> next_pc == $past(pc_p2));

    // R5
    page_keep_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && form == 3'd1 |=>
            next_pc[ADDR_W-1:OFF_W] == $past(pc_p2[ADDR_W-1:OFF_W]) &&
            next_pc[OFF_W-1:0] == {$past(ibyte0[DATA_W-1 -: 3]), $past(ibyte1)});

    // R6
    long_target_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && form == 3'd2 |=> next_pc == {$past(ibyte1), $past(ibyte2)});

    // R8
    fetch_flag_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && (form == 3'd4 || form == 3'd5) |=> fetch_en);

    // R10
    jump_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && form <= 3'd3 |=> !fetch_en && fetch_addr == '0);
endmodule

bind brgen_top brgen_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .form(form), .pc(pc),
    .ibyte0(ibyte0), .ibyte1(ibyte1), .ibyte2(ibyte2), .cond_true(cond_true),
    .out_valid(out_valid), .next_pc(next_pc), .fetch_addr(fetch_addr),
    .fetch_en(fetch_en)
);

// File: tb/brgen_top_tb.sv
module brgen_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  form = '0;
    logic [15:0] pc = '0;
    logic [7:0]  ibyte0 = '0;
    logic [7:0]  ibyte1 = '0;
    logic [7:0]  ibyte2 = '0;
    logic [7:0]  acc = '0;
    logic [15:0] dptr = '0;
    logic        cond_true = 1'b0;
    logic        out_valid;
    logic [15:0] next_pc;
    logic [15:0] fetch_addr;
    logic        fetch_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    brgen_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .form(form), .pc(pc),
        .ibyte0(ibyte0), .ibyte1(ibyte1), .ibyte2(ibyte2), .acc(acc),
        .dptr(dptr), .cond_true(cond_true), .out_valid(out_valid),
        .next_pc(next_pc), .fetch_addr(fetch_addr), .fetch_en(fetch_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input int f, input int p, input int b0, input int b1,
                       input int b2, input int a, input int d, input bit c,
                       input int e_npc, input int e_fa, input bit e_fen,
                       input string tag);
        @(negedge clk);
        form = 3'(f); pc = 16'(p); ibyte0 = 8'(b0); ibyte1 = 8'(b1);
        ibyte2 = 8'(b2); acc = 8'(a); dptr = 16'(d); cond_true = c;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 valid", int'(out_valid), 1);
        chk(tag, int'(next_pc), e_npc & 16'hFFFF);
        if (e_fen) begin
            chk(tag, int'(fetch_en), 1);
            chk(tag, int'(fetch_addr), e_fa & 16'hFFFF);
        end else begin
            chk("R10 fetch_en", int'(fetch_en), 0);
            chk("R10 fetch_addr", int'(fetch_addr), 0);
        end
    endtask

    function automatic int sx(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int pcs[5] = '{16'h0000, 16'h1234, 16'h7F80, 16'hFFFE, 16'hFFFF};
        int pgs[5] = '{16'h0000, 16'h07FD, 16'h07FE, 16'h5A3C, 16'hFFFE};
        int dps[4] = '{16'h0000, 16'h1234, 16'hFF80, 16'hFFFF};
        int fps[3] = '{16'h0000, 16'hFF00, 16'hFFFF};
        logic [15:0] held;

        repeat (3) @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 next_pc", int'(next_pc), 0);
        chk("R1 fetch_addr", int'(fetch_addr), 0);
        chk("R1 fetch_en", int'(fetch_en), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", int'(out_valid) | int'(next_pc) | int'(fetch_en), 0);

        // R3 and R4: every displacement, both condition values
        for (int i = 0; i < 5; i++)
            for (int dsp = 0; dsp < 256; dsp++) begin
                run(0, pcs[i], 8'h80, dsp, 8'hA5, dsp ^ 8'h3C, 16'hBEEF, 1'b1,
                    pcs[i] + 2 + sx(dsp), 0, 1'b0, "R3 rel taken");
                run(0, pcs[i], 8'h80, dsp, 8'hA5, dsp, 16'hBEEF, 1'b0,
                    pcs[i] + 2, 0, 1'b0, "R4 rel not taken");
            end

        // R5: all page-select values, page crossing and wrap
        for (int i = 0; i < 5; i++)
            for (int s = 0; s < 8; s++)
                for (int lo = 0; lo < 256; lo += 51) begin
                    run(1, pgs[i], (s << 5) | 5'h13, lo, 8'h77, 8'h11, 16'h2222, 1'b0,
                        ((pgs[i] + 2) & 16'hF800) | (s << 8) | lo, 0, 1'b0, "R5 page");
                end

        // R6: long jump over all high bytes
        for (int h = 0; h < 256; h++)
            run(2, 16'h4321, 8'h02, h, h ^ 8'hC3, 8'h09, 16'h0F0F, h[0],
                (h << 8) | (h ^ 8'hC3), 0, 1'b0, "R6 long");

        // R7, R8, R9: every accumulator value
        for (int a = 0; a < 256; a++) begin
            for (int i = 0; i < 4; i++)
                run(3, 16'h3000, 8'h73, 8'h00, 8'h00, a, dps[i], 1'b1,
                    dps[i] + a, 0, 1'b0, "R7 indexed jump");
            for (int i = 0; i < 3; i++) begin
                run(4, fps[i], 8'h83, 8'h00, 8'h00, a, 16'h5555, 1'b0,
                    fps[i] + 1, fps[i] + 1 + a, 1'b1, "R8 pc fetch");
                run(5, fps[i], 8'h93, 8'h00, 8'h00, a, dps[i], 1'b0,
                    fps[i] + 1, dps[i] + a, 1'b1, "R9 ptr fetch");
            end
        end

        // R11: explicit wrap corners
        run(0, 16'hFFFF, 0, 8'h7F, 0, 0, 0, 1'b1, 16'h0080, 0, 1'b0, "R11 rel wrap");
        run(3, 0, 0, 0, 0, 8'hFF, 16'hFFFF, 1'b0, 16'h00FE, 0, 1'b0, "R11 jump wrap");
        run(4, 16'hFFFF, 0, 0, 0, 0, 0, 1'b0, 16'h0000, 16'h0000, 1'b1, "R11 fetch wrap");

        // R13: reserved forms
        for (int f = 6; f < 8; f++)
            run(f, 16'hFFFF - f, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 16'hFFFF, 1'b1,
                16'hFFFF - f + 1, 0, 1'b0, "R13 reserved");

        // R12: idle cycles with moving inputs hold the outputs
        run(5, 16'h1000, 0, 0, 0, 8'h10, 16'h2000, 1'b0, 16'h1001, 16'h2010, 1'b1, "R12 setup");
        held = next_pc;
        for (int k = 0; k < 4; k++) begin
            form = 3'(k); pc = 16'(k * 16'h1111); acc = 8'(k + 1); ibyte1 = 8'(k);
            @(negedge clk);
            chk("R12 idle valid", int'(out_valid), 0);
            chk("R12 idle next_pc", int'(next_pc), int'(held));
            chk("R12 idle fetch_addr", int'(fetch_addr), 16'h2010);
            chk("R12 idle fetch_en", int'(fetch_en), 1);
        end

        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end
endmodule